// File: doc/BRIEF.md
# Echo Delay Line Controller

The block runs a sample memory as a circular audio delay line. Each accepted input sample is stored at a write address that then advances by one. In the same sample period an older sample is read back from an address that trails the write address by a delay offset, measured in samples. A two-bit range input chooses one of three fixed offsets. Fine tuning of the delay is done outside the block, by changing the sample rate.

A freeze control stops all writing. The block then plays the last offset-length stretch of recorded audio over and over. The offset that was in use when the freeze began is kept until the freeze ends. A cascade control passes every first-stage result through a second memory that uses the same pointers, which doubles the delay.

Each memory is a synchronous model with a registered read. The block does its accesses in a fixed per-sample order: idle, then write, then read. The output register loads one clock after the read.

Top module: `echo_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, smp_o is 0 and smp_valid_o is 0 until the first sample has been processed. The first accepted sample is stored at address 0.
- R2: smp_valid_i is accepted only while the block is idle, and a strobe seen during the write or read cycle is ignored. For each accepted sample, smp_valid_o is high for exactly one cycle: the fourth clock cycle after the cycle in which the strobe was accepted.
- R3: Each sample accepted outside freeze advances the write address by exactly one, modulo 2^ADDR_W. The delay stays exact after the address wraps.
- R4: With freeze and cascade low, smp_o equals the sample accepted D samples earlier. D is OFS0 for range_i=0, OFS1 for range_i=1 and OFS2 for range_i=2. range_i is sampled with each accepted sample.
- R5: range_i=3 selects OFS2.
- R6: A sample accepted with hold_i high is not stored. During the freeze the output steps through the last D recorded samples, oldest first, and repeats with period D.
- R7: D is latched when a freeze begins. Changes on range_i while hold_i stays high have no effect.
- R8: After hold_i is released, writing resumes at the address that follows the last write made before the freeze. The output continues as if the frozen samples had never been accepted.
- R9: With cascade_i high and the range unchanged for at least 2D samples, smp_o equals the sample accepted 2D samples earlier.
- R10: smp_o changes only in a cycle where smp_valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | New input sample strobe |
| smp_i | input | DATA_W | Input sample |
| range_i | input | 2 | Delay range select |
| hold_i | input | 1 | Freeze recorded loop |
| cascade_i | input | 1 | Route output through the second stage |
| smp_o | output | DATA_W | Delayed output sample |
| smp_valid_o | output | 1 | Output sample strobe |

## Verification
The assertions check on every cycle the order of the per-sample phases and the single-cycle output strobe. They also check that the write address steps by one per recorded sample and stays still during a freeze, that the loop read address stays inside the frozen window, that the latched offset is held, and that the output is stable between strobes. Only the bench scenarios can show that the data leaving the block is the correct older sample. This covers each range, a point after the address wraps, cascaded double delay, the content and period of the frozen loop, and resumption after a freeze. The values are computed from a record of the accepted samples.

// File: rtl/echo_pkg.sv
package echo_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2
  } phase_e;

  localparam int unsigned RANGE_W = 2;
endpackage

// File: rtl/echo_seq.sv
module echo_seq
  import echo_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  output phase_e phase_o,
  output logic   rd_done_o
);
  phase_e phase_q, phase_d;
  logic   rd_done_q;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:  if (start_i) phase_d = PH_WRITE;
      PH_WRITE: phase_d = PH_READ;
      PH_READ:  phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      rd_done_q <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      rd_done_q <= (phase_q == PH_READ);
    end
  end

  assign phase_o   = phase_q;
  assign rd_done_o = rd_done_q;

  AST_WRITE_THEN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_WRITE |=> phase_q == PH_READ); // R2
  AST_READ_THEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_READ |=> phase_q == PH_IDLE); // R2
endmodule

// File: rtl/echo_ptr.sv
module echo_ptr
  import echo_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned OFS0   = 64,
  parameter int unsigned OFS1   = 256,
  parameter int unsigned OFS2   = 1023
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               accept_i,
  input  logic [RANGE_W-1:0] range_i,
  input  logic               hold_i,
  input  phase_e             phase_i,
  output logic               wr_en_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [ADDR_W-1:0]  tail_addr_o,
  output logic [ADDR_W-1:0]  rd_addr_o
);
  typedef logic [ADDR_W-1:0] addr_t;
  localparam addr_t OfsA = addr_t'(OFS0);
  localparam addr_t OfsB = addr_t'(OFS1);
  localparam addr_t OfsC = addr_t'(OFS2);

  addr_t wp_q, ofs_q, loop_end_q, play_q;
  addr_t ofs_sel, play_nxt, loop_dist;
  logic  hold_q;

  always_comb begin
    case (range_i)
      2'd0:    ofs_sel = OfsA;
      2'd1:    ofs_sel = OfsB;
      default: ofs_sel = OfsC;
    endcase
  end

  assign play_nxt  = play_q + addr_t'(1);
  assign loop_dist = loop_end_q - play_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q       <= '0;
      ofs_q      <= OfsA;
      loop_end_q <= '0;
      play_q     <= '0;
      hold_q     <= 1'b0;
    end else begin
      if (accept_i) begin
        hold_q <= hold_i;
        if (!hold_i) begin
          ofs_q <= ofs_sel;
        end else if (!hold_q) begin
          // freeze entry: latch loop window
          ofs_q      <= ofs_sel;
          loop_end_q <= wp_q;
          play_q     <= wp_q - ofs_sel;
        end
      end
      if (phase_i == PH_READ) begin
        if (hold_q) play_q <= (play_nxt == loop_end_q) ? loop_end_q - ofs_q : play_nxt;
        else        wp_q   <= wp_q + addr_t'(1);
      end
    end
  end

  assign wr_en_o     = (phase_i == PH_WRITE) && !hold_q;
  assign wr_addr_o   = wp_q;
  assign tail_addr_o = wp_q - addr_t'(1);
  assign rd_addr_o   = hold_q ? play_q : wp_q - ofs_q;

  AST_WP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_READ && !hold_q) |=> (wp_q - $past(wp_q)) == addr_t'(1)); // R3
  AST_WP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_READ && hold_q) |=> $stable(wp_q)); // R6
  AST_LOOP_INSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_READ && hold_q) |-> (loop_dist != '0 && loop_dist <= ofs_q)); // R6
  AST_OFS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && hold_i && hold_q) |=> $stable(ofs_q)); // R7
endmodule

// File: rtl/echo_mem.sv
module echo_mem #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 4
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned Depth = 1 << AW;

  logic [DW-1:0] mem_q [Depth];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/echo_ctrl.sv
module echo_ctrl
  import echo_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 4,
  parameter int unsigned OFS0   = 64,
  parameter int unsigned OFS1   = 256,
  parameter int unsigned OFS2   = 1023
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_i,
  input  logic [1:0]        range_i,
  input  logic              hold_i,
  input  logic              cascade_i,
  output logic [DATA_W-1:0] smp_o,
  output logic              smp_valid_o
);
  localparam int unsigned NumStages = 2;

  phase_e            phase;
  logic              rd_done, accept, wr_en;
  logic [ADDR_W-1:0] wr_addr, tail_addr, rd_addr;
  logic [DATA_W-1:0] smp_q, stage1_q, out_q;
  logic              casc_q, valid_q;
  logic [DATA_W-1:0] rdata [NumStages];

  assign accept = (phase == PH_IDLE) && smp_valid_i;

  echo_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (smp_valid_i),
    .phase_o   (phase),
    .rd_done_o (rd_done)
  );

  echo_ptr #(
    .ADDR_W (ADDR_W),
    .OFS0   (OFS0),
    .OFS1   (OFS1),
    .OFS2   (OFS2)
  ) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .range_i     (range_i),
    .hold_i      (hold_i),
    .phase_i     (phase),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .tail_addr_o (tail_addr),
    .rd_addr_o   (rd_addr)
  );

  for (genvar s = 0; s < NumStages; s++) begin : g_stage
    logic [ADDR_W-1:0] waddr;
    logic [DATA_W-1:0] wdata;
    if (s == 0) begin : g_first
      assign waddr = wr_addr;
      assign wdata = smp_q;
    end else begin : g_next
      // previous sample's first-stage result goes to the slot written last period
      assign waddr = tail_addr;
      assign wdata = stage1_q;
    end
    echo_mem #(
      .AW (ADDR_W),
      .DW (DATA_W)
    ) u_mem (
      .clk_i   (clk_i),
      .we_i    (wr_en),
      .waddr_i (waddr),
      .wdata_i (wdata),
      .re_i    (phase == PH_READ),
      .raddr_i (rd_addr),
      .rdata_o (rdata[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q    <= '0;
      casc_q   <= 1'b0;
      stage1_q <= '0;
      out_q    <= '0;
      valid_q  <= 1'b0;
    end else begin
      if (accept) begin
        smp_q  <= smp_i;
        casc_q <= cascade_i;
      end
      valid_q <= rd_done;
      if (rd_done) begin
        stage1_q <= rdata[0];
        out_q    <= casc_q ? rdata[NumStages-1] : rdata[0];
      end
    end
  end

  assign smp_o       = out_q;
  assign smp_valid_o = valid_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |=> !smp_valid_o); // R2
  AST_OUT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_o |-> $stable(smp_o)); // R10
endmodule

// File: tb/echo_ctrl_bench.sv
`timescale 1ns/1ps
module echo_ctrl_bench;
  localparam int AW = 6;
  localparam int DW = 4;
  localparam int D0 = 3;
  localparam int D1 = 10;
  localparam int D2 = 63;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [DW-1:0] din = '0;
  logic [1:0]    range = 2'd0;
  logic          hold = 1'b0;
  logic          casc = 1'b0;
  logic [DW-1:0] dout;
  logic          dvalid;

  int rec [4096];
  int w = 0;
  int g = 0;
  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  echo_ctrl #(
    .ADDR_W (AW),
    .DATA_W (DW),
    .OFS0   (D0),
    .OFS1   (D1),
    .OFS2   (D2)
  ) u_echo_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .smp_valid_i (valid),
    .smp_i       (din),
    .range_i     (range),
    .hold_i      (hold),
    .cascade_i   (casc),
    .smp_o       (dout),
    .smp_valid_o (dvalid)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  function automatic int f(input int i);
    return (i * 7 + (i >> 3)) & 15;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_sample(input bit dbl, input bit frz, input int exp, input bit use_exp,
                           input string req);
    logic [DW-1:0] x;
    logic [DW-1:0] got;
    int lat;
    int pulses;
    x = DW'(f(g));
    g++;
    got = '0;
    lat = 0;
    pulses = 0;
    @(negedge clk);
    valid = 1'b1;
    din = x;
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk);
      if (c == 1) begin
        if (dbl) din = ~x;
        else valid = 1'b0;
      end
      if (c == 2) valid = 1'b0;
      if (dvalid) begin
        pulses++;
        if (pulses == 1) begin
          lat = c;
          got = dout;
        end
      end
    end
    chk(lat == 4, "R2", lat, 4);
    chk(pulses == 1, "R2", pulses, 1);
    if (use_exp) chk(int'(got) == exp, req, int'(got), exp);
    chk(dout == got, "R10", int'(dout), int'(got));
    if (!frz) begin
      rec[w] = int'(x);
      w++;
    end
  endtask

  task automatic run_normal(input int n, input int d, input bit cas, input int skip,
                            input string req);
    for (int i = 0; i < n; i++) begin
      int tot;
      bit u;
      tot = cas ? 2 * d : d;
      u = (i >= skip) && (w >= tot);
      do_sample(1'b0, 1'b0, u ? rec[w - tot] : 0, u, req);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(dout == '0, "R1", int'(dout), 0);
    chk(dvalid == 1'b0, "R1", int'(dvalid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dout == '0, "R1", int'(dout), 0);
    chk(dvalid == 1'b0, "R1", int'(dvalid), 0);

    // R4 short delay, then R3 across the address wrap
    range = 2'd0;
    run_normal(40, D0, 1'b0, 0, "R4");
    run_normal(70, D0, 1'b0, 0, "R3");
    // R4 other ranges
    range = 2'd1;
    run_normal(60, D1, 1'b0, 0, "R4");
    range = 2'd2;
    run_normal(70, D2, 1'b0, 0, "R4");
    // R5 code 3 maps to the longest offset
    range = 2'd3;
    run_normal(40, D2, 1'b0, 0, "R5");

    // R2 strobe held into the write cycle: only the first value is stored
    range = 2'd0;
    for (int i = 0; i < 6; i++) do_sample(1'b1, 1'b0, rec[w - D0], 1'b1, "R2");
    run_normal(6, D0, 1'b0, 0, "R2");

    // R9 cascade doubles the delay
    casc = 1'b1;
    run_normal(40, D0, 1'b1, 2 * D0 + 2, "R9");
    range = 2'd1;
    run_normal(50, D1, 1'b1, 2 * D1 + 2, "R9");
    casc = 1'b0;
    run_normal(20, D1, 1'b0, 0, "R4");

    // R6 / R7 freeze loop
    begin
      int w0;
      w0 = w;
      hold = 1'b1;
      for (int k = 0; k < 35; k++) begin
        if (k == 15) range = 2'd0;
        do_sample(1'b0, 1'b1, rec[w0 - D1 + (k % D1)], 1'b1, (k >= 15) ? "R7" : "R6");
      end
      hold = 1'b0;
      range = 2'd1;
    end
    // R8 release continues the recording where it stopped
    run_normal(25, D1, 1'b0, 0, "R8");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule